// File: doc/BRIEF.md
# Three-Wire Radio Register Access Master

This block lets an on-chip host read and write the control registers of an external radio over three wires. The wires are a shift clock, one shared data line and a load-enable strobe. The block is always the master and always produces the shift clock. The host pulses `start_i` together with a read/write select, an 8-bit register address and, for writes, a 16-bit word. The block then serializes the frame MSB first. Data changes while the shift clock is low, and the radio samples it on the rising edge.

A write shifts out 8 address bits and then 16 data bits. The block then raises load-enable for one shift-clock period, and the rising edge inside that period commits the word in the radio. A read shifts out only the address. It then raises load-enable and stops driving the data line before the next rising edge, which is the edge on which the radio takes the line over. After that the block samples 16 bits from the radio, one on each of the following rising edges. Both kinds of frame take 25 shift-clock periods. `done_o` pulses for one system clock at the end of each frame.

The pin output enables stay low until `en_i` is raised. While `en_i` is low, a start pulse is not accepted.

Top module: `rf3w_master`

## Requirements
- R1: After reset the block is idle, with `busy_o`, `done_o`, `sclk_o` and `sle_o` low and `sdat_oe_o` low. While `en_i` is low, `sclk_oe_o`, `sle_oe_o` and `sdat_oe_o` are all low and `start_i` is not accepted. While `en_i` is high, `sclk_oe_o` and `sle_oe_o` are high.
- R2: The shift clock runs only during a frame, at the system clock divided by CLK_DIV with a 50% duty cycle, and idles low. Each frame has exactly 25 rising edges: 8 + 16 + 1.
- R3: Outgoing bits are MSB first. A write sends address[7:0] and then data[15:0]. `sdat_o` does not change while the shift clock is high and the line is driven.
- R4: After the last data bit of a write, `sle_o` is high for exactly CLK_DIV system clocks, which is one shift-clock period. That period contains exactly one rising shift-clock edge, on which the radio commits the 24-bit word.
- R5: On a read, after the 8 address bits, `sle_o` rises and `sdat_oe_o` falls before the next rising edge. The radio drives the line from the following falling edge. The block samples `sdat_i` on the next 16 rising edges, MSB first, into `rdata_o`, and it never drives the line while the radio does.
- R6: `done_o` is high for one system clock. It is first high 25*CLK_DIV+1 clock cycles after the clock edge that samples the accepted start. `rdata_o` is valid from that cycle on.
- R7: A start pulse that arrives while `busy_o` is high is ignored. The frame in progress completes unchanged, and no further frame follows it.
- R8: A write frame leaves `rdata_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Pin enable; high hands the three pins to the block |
| start_i | input | 1 | Start pulse for a frame |
| rd_i | input | 1 | 1 = read, 0 = write; sampled with the start |
| addr_i | input | 8 | Radio register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Data captured by the last read |
| done_o | output | 1 | One-cycle pulse at the end of a frame |
| busy_o | output | 1 | A frame is in progress |
| sclk_o | output | 1 | Shift clock |
| sclk_oe_o | output | 1 | Output enable for the shift clock pin |
| sle_o | output | 1 | Load-enable strobe |
| sle_oe_o | output | 1 | Output enable for the load-enable pin |
| sdat_o | output | 1 | Data line output value |
| sdat_oe_o | output | 1 | Data line output enable |
| sdat_i | input | 1 | Data line input value |

## Verification
The hardest case to reach is the read turnaround. Here the master's release and the radio's takeover must fall on opposite sides of one rising edge, and any overlap is bus contention. The bench therefore contains a reactive radio model that takes the line only on the falling edge after it sees load-enable at a rising edge. The bench counts every cycle in which both sides drive the line, and it checks that the master has let go by the strobe's rising edge. A second hard case is a start pulse injected in the middle of a frame with the opposite direction and a different address. The bench then checks that the frame and the commit count are unaffected and that the clock stays quiet afterwards.

// File: rtl/rf3w_pkg.sv
package rf3w_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WDATA,
    ST_STROBE,
    ST_RDATA
  } rf3w_state_e;

  function automatic int unsigned frame_slots(int unsigned aw, int unsigned dw);
    return aw + dw + 1;
  endfunction
endpackage

// File: rtl/rf3w_clkgen.sv
module rf3w_clkgen #(
  parameter int unsigned CLK_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned HALF = CLK_DIV / 2;
  localparam int unsigned PH_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CLK_DIV - 1);
  localparam logic [PH_W-1:0] PH_MID  = PH_W'(HALF - 1);

  logic [PH_W-1:0] ph_q;
  logic            sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= '0;
      sclk_q <= 1'b0;
    end else if (!run_i) begin
      ph_q   <= '0;
      sclk_q <= 1'b0;
    end else if (ph_q == PH_LAST) begin
      ph_q   <= '0;
      sclk_q <= 1'b0;
    end else begin
      ph_q <= ph_q + 1'b1;
      if (ph_q == PH_MID) sclk_q <= 1'b1;
    end
  end

  // strobes mark the cycle whose closing edge moves the shift clock
  assign rise_o = run_i && (ph_q == PH_MID);
  assign fall_o = run_i && (ph_q == PH_LAST);
  assign sclk_o = sclk_q;
endmodule

// File: rtl/rf3w_seq.sv
module rf3w_seq
  import rf3w_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic start_i,
  input  logic rd_i,
  input  logic rise_i,
  input  logic fall_i,
  output logic accept_o,
  output logic shift_o,
  output logic capture_o,
  output logic busy_o,
  output logic done_o,
  output logic sle_o,
  output logic drive_o
);
  localparam int unsigned MAXW  = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
  localparam int unsigned CNT_W = $clog2(MAXW);
  localparam logic [CNT_W-1:0] A_LAST = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] D_LAST = CNT_W'(DATA_W - 1);

  rf3w_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rd_q, done_q, sle_q, drive_q;

  assign accept_o = start_i && en_i && (state_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rd_q    <= 1'b0;
      done_q  <= 1'b0;
      sle_q   <= 1'b0;
      drive_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept_o) begin
        state_q <= ST_ADDR;
        cnt_q   <= '0;
        rd_q    <= rd_i;
        drive_q <= 1'b1;
      end else if (fall_i) begin
        unique case (state_q)
          ST_ADDR: begin
            if (cnt_q == A_LAST) begin
              cnt_q <= '0;
              if (rd_q) begin
                // release the line before the turnaround edge
                state_q <= ST_STROBE;
                sle_q   <= 1'b1;
                drive_q <= 1'b0;
              end else begin
                state_q <= ST_WDATA;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_WDATA: begin
            if (cnt_q == D_LAST) begin
              cnt_q   <= '0;
              state_q <= ST_STROBE;
              sle_q   <= 1'b1;
              drive_q <= 1'b0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_STROBE: begin
            sle_q <= 1'b0;
            if (rd_q) begin
              state_q <= ST_RDATA;
            end else begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end
          end
          ST_RDATA: begin
            if (cnt_q == D_LAST) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign shift_o   = fall_i && ((state_q == ST_ADDR) || (state_q == ST_WDATA));
  assign capture_o = rise_i && (state_q == ST_RDATA);
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign sle_o     = sle_q;
  assign drive_o   = drive_q;
endmodule

// File: rtl/rf3w_shifter.sv
module rf3w_shifter #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              shift_i,
  input  logic              capture_i,
  input  logic              sdat_i,
  output logic              sdat_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned TX_W = ADDR_W + DATA_W;

  logic [TX_W-1:0]   tx_q;
  logic [DATA_W-1:0] rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0;
    end else if (load_i) begin
      tx_q <= {addr_i, wdata_i};
    end else if (shift_i) begin
      tx_q <= {tx_q[TX_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q <= '0;
    end else if (capture_i) begin
      rx_q <= {rx_q[DATA_W-2:0], sdat_i};
    end
  end

  assign sdat_o  = tx_q[TX_W-1];
  assign rdata_o = rx_q;
endmodule

// File: rtl/rf3w_master.sv
module rf3w_master #(
  parameter int unsigned CLK_DIV = 4,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              start_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o,
  output logic              busy_o,
  output logic              sclk_o,
  output logic              sclk_oe_o,
  output logic              sle_o,
  output logic              sle_oe_o,
  output logic              sdat_o,
  output logic              sdat_oe_o,
  input  logic              sdat_i
);
  logic rise, fall, accept, shift, capture, drive;

  rf3w_clkgen #(.CLK_DIV(CLK_DIV)) u_clkgen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_o),
    .sclk_o (sclk_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  rf3w_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .start_i   (start_i),
    .rd_i      (rd_i),
    .rise_i    (rise),
    .fall_i    (fall),
    .accept_o  (accept),
    .shift_o   (shift),
    .capture_o (capture),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .sle_o     (sle_o),
    .drive_o   (drive)
  );

  rf3w_shifter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (accept),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .shift_i   (shift),
    .capture_i (capture),
    .sdat_i    (sdat_i),
    .sdat_o    (sdat_o),
    .rdata_o   (rdata_o)
  );

  assign sclk_oe_o = en_i;
  assign sle_oe_o  = en_i;
  assign sdat_oe_o = en_i && drive;
endmodule

// File: rtl/rf3w_checker.sv
module rf3w_checker #(
  parameter int unsigned CLK_DIV = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic done_o,
  input logic busy_o,
  input logic sclk_o,
  input logic sclk_oe_o,
  input logic sle_o,
  input logic sle_oe_o,
  input logic sdat_o,
  input logic sdat_oe_o
);
  localparam int unsigned SC_W = $clog2(CLK_DIV + 2) + 1;
  logic [SC_W-1:0] sle_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sle_cnt_q <= '0;
    else if (sle_o) sle_cnt_q <= sle_cnt_q + 1'b1;
    else            sle_cnt_q <= '0;
  end

  a_r1_pins_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (!sclk_oe_o && !sle_oe_o && !sdat_oe_o));

  a_r2_sclk_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !sclk_o);

  a_r3_data_stable_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sdat_oe_o && sclk_o && $past(sclk_o) && $past(sdat_oe_o)) |-> $stable(sdat_o));

  a_r4_sle_one_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sle_o) |-> (sle_cnt_q == SC_W'(CLK_DIV)));

  a_r4_sle_rise_sclk_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sle_o) |-> !sclk_o);

  a_r5_no_drive_in_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sle_o |-> !sdat_oe_o);

  a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r6_done_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

bind rf3w_master rf3w_checker #(.CLK_DIV(CLK_DIV)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .done_o    (done_o),
  .busy_o    (busy_o),
  .sclk_o    (sclk_o),
  .sclk_oe_o (sclk_oe_o),
  .sle_o     (sle_o),
  .sle_oe_o  (sle_oe_o),
  .sdat_o    (sdat_o),
  .sdat_oe_o (sdat_oe_o)
);

// File: tb/tb_rf3w_master.sv
module tb_rf3w_master;
  localparam int DIV   = 4;
  localparam int SLOTS = 25;
  localparam int LAT   = SLOTS * DIV + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, start = 1'b0, rd = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata_o;
  logic done_o, busy_o, sclk_o, sclk_oe_o, sle_o, sle_oe_o, sdat_o, sdat_oe_o, sdat_i;

  always #4 clk = ~clk;

  rf3w_master dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .start_i(start), .rd_i(rd),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata_o), .done_o(done_o),
    .busy_o(busy_o), .sclk_o(sclk_o), .sclk_oe_o(sclk_oe_o), .sle_o(sle_o),
    .sle_oe_o(sle_oe_o), .sdat_o(sdat_o), .sdat_oe_o(sdat_oe_o), .sdat_i(sdat_i)
  );

  int n_chk = 0, n_err = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] reg_val(input logic [7:0] a);
    return {a ^ 8'hC3, ~a} ^ 16'h1234;
  endfunction

  // radio model
  bit          cur_rd = 1'b0;
  int          rises = 0, commits = 0, strobe_oe = 0;
  logic [23:0] rx_sr = '0, latched = '0;
  logic [15:0] rword = '0;
  logic        arm = 1'b0, rdrive = 1'b0, drv_bit = 1'b1;
  int          nsent = 0;

  assign sdat_i = rdrive ? drv_bit : 1'b1;

  always @(posedge sclk_o or negedge sclk_o) begin
    if (sclk_o) begin
      rises <= rises + 1;
      if (sle_o) begin
        commits <= commits + 1;
        if (sdat_oe_o) strobe_oe <= strobe_oe + 1;
        if (!cur_rd) latched <= rx_sr;
        else begin
          rword <= reg_val(rx_sr[7:0]);
          arm   <= 1'b1;
          nsent <= 0;
        end
      end else if (sdat_oe_o) begin
        rx_sr <= {rx_sr[22:0], sdat_o};
      end
    end else if (arm) begin
      if (nsent < 16) begin
        drv_bit <= rword[15-nsent];
        rdrive  <= 1'b1;
        nsent   <= nsent + 1;
      end else begin
        rdrive <= 1'b0;
        arm    <= 1'b0;
      end
    end
  end

  // cycle monitors
  int   sle_cyc = 0, hi_cyc = 0, contention = 0, hold_viol = 0, busy_seen = 0;
  logic p_sclk = 1'b0, p_oe = 1'b0, p_sdat = 1'b0;

  always @(negedge clk) begin
    if (sle_o) sle_cyc <= sle_cyc + 1;
    if (sclk_o) hi_cyc <= hi_cyc + 1;
    if (busy_o) busy_seen <= busy_seen + 1;
    if (rdrive && sdat_oe_o) contention <= contention + 1;
    if (sclk_o && p_sclk && sdat_oe_o && p_oe && (sdat_o != p_sdat)) hold_viol <= hold_viol + 1;
    p_sclk <= sclk_o;
    p_oe   <= sdat_oe_o;
    p_sdat <= sdat_o;
  end

  task automatic run_txn(input bit r, input logic [7:0] a, input logic [15:0] d,
                         input bit inject);
    int r0, s0, c0, h0, con0, hv0, so0, lat;
    logic [15:0] prev_rd;
    r0 = rises; s0 = sle_cyc; c0 = commits; h0 = hi_cyc;
    con0 = contention; hv0 = hold_viol; so0 = strobe_oe;
    prev_rd = rdata_o;
    cur_rd = r;
    @(negedge clk);
    rd = r; addr = a; wdata = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done_o && lat < 2000) begin
      if (inject && lat == 10) begin
        start = 1'b1; rd = ~r; addr = ~a; wdata = ~d;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    check(lat == LAT, "R6", "done latency", lat, LAT);
    check(rises - r0 == SLOTS, "R2", "rising edges per frame", rises - r0, SLOTS);
    check(hi_cyc - h0 == SLOTS * DIV / 2, "R2", "sclk high cycles", hi_cyc - h0, SLOTS * DIV / 2);
    check(sle_cyc - s0 == DIV, "R4", "sle high cycles", sle_cyc - s0, DIV);
    check(commits - c0 == 1, "R4", "strobed rising edges", commits - c0, 1);
    check(hold_viol == hv0, "R3", "data moved while sclk high", hold_viol - hv0, 0);
    if (r) begin
      check(contention == con0, "R5", "bus contention cycles", contention - con0, 0);
      check(strobe_oe == so0, "R5", "driving at turnaround edge", strobe_oe - so0, 0);
      check(rdata_o == reg_val(a), "R5", "read data", rdata_o, reg_val(a));
    end else begin
      check(latched == {a, d}, "R3", "committed word", latched, {a, d});
      check(rdata_o == prev_rd, "R8", "rdata after write", rdata_o, prev_rd);
    end
    @(negedge clk);
    check(!done_o, "R6", "done width", done_o, 0);
    if (inject) begin
      r0 = rises;
      repeat (SLOTS * DIV) @(negedge clk);
      check(!busy_o && rises == r0, "R7", "frame after ignored start", rises - r0, 0);
    end
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_err++;
    $display("FAIL R6 watchdog expired: actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int b0;
    void'($urandom(32'd1337));
    repeat (3) @(negedge clk);
    check(!sclk_oe_o && !sle_oe_o && !sdat_oe_o, "R1", "pins in reset",
          {sclk_oe_o, sle_oe_o, sdat_oe_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy_o && !done_o && !sclk_o && !sle_o, "R1", "idle after reset",
          {busy_o, done_o, sclk_o, sle_o}, 0);
    // start with pins disabled must not be accepted
    b0 = busy_seen;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (SLOTS * DIV + 4) @(negedge clk);
    check(busy_seen == b0 && rises == 0, "R1", "start while disabled", busy_seen - b0, 0);
    check(!sclk_oe_o && !sle_oe_o && !sdat_oe_o, "R1", "pins disabled",
          {sclk_oe_o, sle_oe_o, sdat_oe_o}, 0);
    en = 1'b1;
    @(negedge clk);
    check(sclk_oe_o && sle_oe_o && !sdat_oe_o, "R1", "pins enabled idle",
          {sclk_oe_o, sle_oe_o, sdat_oe_o}, 3'b110);

    run_txn(1'b0, 8'h00, 16'h0000, 1'b0);
    run_txn(1'b0, 8'hFF, 16'hFFFF, 1'b0);
    run_txn(1'b0, 8'h80, 16'h0001, 1'b0);
    run_txn(1'b1, 8'hA5, 16'h0000, 1'b0);
    run_txn(1'b1, 8'h00, 16'h0000, 1'b0);
    run_txn(1'b0, 8'h3C, 16'hBEEF, 1'b0);
    run_txn(1'b0, 8'h12, 16'h3456, 1'b1);
    run_txn(1'b1, 8'h7E, 16'h0000, 1'b1);
    for (int i = 0; i < 24; i++) begin
      run_txn(1'($urandom), 8'($urandom), 16'($urandom), 1'($urandom % 4 == 0));
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule